// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit accumulator driven by one asynchronous pulse pin. It has two modes. In event mode it adds one for each qualifying edge on the pin. In gated mode it adds one for each tick of an internal 1-in-64 prescaled strobe, but only while the pin sits at the level that opens the gate. One polarity bit selects the counted edge in event mode and the inhibiting level in gated mode.

Software reaches the block through a small register bus with three locations: control, counter and flags. The control location also holds a channel select bit and a two-bit rate code. The block does not use either of them; it drives both straight out to neighbouring timer logic. Two sticky flags report a counter wrap and an active pin edge. Software clears each flag by writing a one to its bit.

Top module: `pacc_top`

## Requirements
- R1: After reset the control register, the counter and both flags read zero, and `chan_sel` and `rate_sel` are zero.
- R2: The control register is at address 0. Bit 6 is enable, bit 5 is mode (1 = gated), bit 4 is polarity, bit 2 is channel select and bits 1:0 are the rate code. Bits 7 and 3 always read zero. Bit 2 drives `chan_sel` and bits 1:0 drive `rate_sel`.
- R3: While enable is 0, pin activity changes neither the counter nor either flag.
- R4: In event mode with polarity 0, each falling edge of the pin adds exactly one to the counter, and a rising edge adds nothing.
- R5: In event mode with polarity 1, each rising edge of the pin adds exactly one to the counter.
- R6: In gated mode with polarity 0, the counter adds one per 64 clocks while the synchronized pin is high. A pin held high for 64·k clocks adds exactly k. A low pin stops counting.
- R7: In gated mode with polarity 1, the counter counts while the pin is low, and a high pin stops counting.
- R8: A count from 0xFF to 0x00 sets the sticky overflow flag (flags bit 0, address 2). Writing a 1 to bit 0 at address 2 clears the overflow flag and leaves the other flag unchanged.
- R9: The active edge sets the sticky edge flag (flags bit 1). The active edge is the falling edge with polarity 0 and the rising edge with polarity 1, in both modes. Writing a 1 to bit 1 at address 2 clears the edge flag.
- R10: The counter is read and written at address 1. A counter write in the same cycle as a count event wins: the written value is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address (0 control, 1 counter, 2 flags) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| pulse_in | input | 1 | Asynchronous pulse pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| edge_flag | output | 1 | Sticky active-edge flag |
| chan_sel | output | 1 | Channel select bit passed to neighbouring logic |
| rate_sel | output | 2 | Rate code passed to neighbouring logic |

## Verification
The assertions check the following on every cycle:
- the counter holds while disabled and while the gate is shut;
- without a write, the counter moves by at most one per cycle;
- a counter write wins over a count event;
- a wrap always raises the overflow flag;
- the reserved control bits read zero;
- prescaler ticks never fall on back-to-back cycles.

Only the directed scenarios can show the following:
- the correct edge direction for each polarity;
- the exact count of k for a gate held open for 64·k clocks;
- the write-one-to-clear behaviour of each flag;
- a write and a count event landing in the same cycle.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_CNT  = 2'd1,
    A_FLAG = 2'd2
  } addr_e;

  // Control field positions: software depends on them.
  localparam int B_EN   = 6;
  localparam int B_MODE = 5;
  localparam int B_POL  = 4;
  localparam int B_SEL  = 2;
  localparam int B_RATE = 0;

  // Flag bit positions
  localparam int F_OVF  = 0;
  localparam int F_EDGE = 1;

  typedef struct packed {
    logic       en;
    logic       mode;
    logic       pol;
    logic       sel;
    logic [1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], din};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  // Supports R4 and R5: an edge strobe never lasts two cycles.
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall) || ($past(rise) != rise));
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q, div_d;

  always_comb begin
    tick  = (div_q == LAST);
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // Supports R6: with DIV > 1, two ticks never fall on back-to-back cycles.
  p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode,
  input  logic         pol,
  input  logic         lvl,
  input  logic         rise,
  input  logic         fall,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         clr_ovf,
  input  logic         clr_edge,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         edg
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d, edg_q, edg_d;
  logic         act_edge, gate_open, inc, wrap;

  always_comb begin
    // The active edge is the counted edge in event mode and the gate-closing edge in gated mode.
    act_edge  = en & (pol ? rise : fall);
    gate_open = lvl ^ pol;
    inc       = en & (mode ? (tick & gate_open) : act_edge);
    wrap      = inc & ~cnt_wr & (cnt_q == FULL);
    if (cnt_wr)   cnt_d = cnt_wdata;
    else if (inc) cnt_d = cnt_q + ONE;
    else          cnt_d = cnt_q;
    ovf_d = wrap     | (ovf_q & ~clr_ovf);
    edg_d = act_edge | (edg_q & ~clr_edge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      edg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      edg_q <= edg_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
  assign edg = edg_q;

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt_q));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE));
  p_gate_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !gate_open && !cnt_wr) |=> $stable(cnt_q));
  p_wrap_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && inc && !cnt_wr) |=> (ovf_q && cnt_q == '0));
  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(cnt_wdata));
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pulse_in,
  output logic              ovf_flag,
  output logic              edge_flag,
  output logic              chan_sel,
  output logic [1:0]        rate_sel
);
  ctrl_t             ctrl_q, ctrl_d;
  logic              lvl, rise, fall, tick;
  logic              ctrl_wr, cnt_wr, flag_wr;
  logic [DATA_W-1:0] cnt;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    cnt_wr  = wr_en && (addr == A_CNT);
    flag_wr = wr_en && (addr == A_FLAG);
    ctrl_d  = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.en   = wr_data[B_EN];
      ctrl_d.mode = wr_data[B_MODE];
      ctrl_d.pol  = wr_data[B_POL];
      ctrl_d.sel  = wr_data[B_SEL];
      ctrl_d.rate = wr_data[B_RATE +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pulse_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  pacc_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pacc_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_q.en), .mode(ctrl_q.mode), .pol(ctrl_q.pol),
    .lvl(lvl), .rise(rise), .fall(fall), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data),
    .clr_ovf(flag_wr & wr_data[F_OVF]),
    .clr_edge(flag_wr & wr_data[F_EDGE]),
    .cnt(cnt), .ovf(ovf_flag), .edg(edge_flag)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: begin
        rd_data[B_EN]        = ctrl_q.en;
        rd_data[B_MODE]      = ctrl_q.mode;
        rd_data[B_POL]       = ctrl_q.pol;
        rd_data[B_SEL]       = ctrl_q.sel;
        rd_data[B_RATE +: 2] = ctrl_q.rate;
      end
      A_CNT:  rd_data = cnt;
      A_FLAG: begin
        rd_data[F_OVF]  = ovf_flag;
        rd_data[F_EDGE] = edge_flag;
      end
      default: rd_data = '0;
    endcase
  end

  assign chan_sel = ctrl_q.sel;
  assign rate_sel = ctrl_q.rate;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rd_data[7] == 1'b0 && rd_data[3] == 1'b0));
  p_sel_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (chan_sel == $past(wr_data[B_SEL]) && rate_sel == $past(wr_data[1:0])));
endmodule

// File: tb/test_pacc_top.sv
module test_pacc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pulse_in = 1'b0;
  logic       ovf_flag, edge_flag, chan_sel;
  logic [1:0] rate_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pacc_top i_pacc_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pulse_in(pulse_in), .ovf_flag(ovf_flag),
    .edge_flag(edge_flag), .chan_sel(chan_sel), .rate_sel(rate_sel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    pulse_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    bus_rd(2'd1, d); check("R1 cnt", d, 8'h00);
    bus_rd(2'd2, d); check("R1 flags", d, 8'h00);
    check("R1 sel/rate", {5'd0, chan_sel, rate_sel}, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, d); check("R2 readback", d, 8'h77);
    check("R2 sel/rate", {5'd0, chan_sel, rate_sel}, 8'h07);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    for (int i = 0; i < 3; i++) begin pin(1'b1); pin(1'b0); end
    bus_rd(2'd1, d); check("R3 cnt", d, 8'h00);
    bus_rd(2'd2, d); check("R3 flags", d, 8'h00);
  endtask

  task automatic t_evt_fall;
    logic [7:0] d;
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h40);
    pin(1'b1);
    bus_rd(2'd1, d); check("R4 rise ignored", d, 8'h00);
    pin(1'b0);
    for (int i = 0; i < 2; i++) begin pin(1'b1); pin(1'b0); end
    bus_rd(2'd1, d); check("R4 three falls", d, 8'h03);
    bus_rd(2'd2, d); check("R9 edge flag set", d, 8'h02);
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd2, d); check("R9 edge flag clear", d, 8'h00);
  endtask

  task automatic t_evt_rise;
    logic [7:0] d;
    bus_wr(2'd0, 8'h50);
    bus_wr(2'd1, 8'h10);
    for (int i = 0; i < 2; i++) begin pin(1'b1); pin(1'b0); end
    bus_rd(2'd1, d); check("R5 two rises", d, 8'h12);
    bus_rd(2'd1, d); check("R10 counter readback", d, 8'h12);
  endtask

  task automatic t_gated_hi;
    logic [7:0] d;
    bus_wr(2'd0, 8'h60);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'h03);
    repeat (200) @(negedge clk);
    bus_rd(2'd1, d); check("R6 low inhibits", d, 8'h00);
    @(negedge clk); pulse_in = 1'b1;
    repeat (320) @(negedge clk);
    pulse_in = 1'b0;
    repeat (10) @(negedge clk);
    bus_rd(2'd1, d); check("R6 320 clocks high", d, 8'h05);
    bus_rd(2'd2, d); check("R9 gated close edge", d, 8'h02);
  endtask

  task automatic t_gated_lo;
    logic [7:0] d;
    bus_wr(2'd0, 8'h00);
    pin(1'b1);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h70);
    repeat (200) @(negedge clk);
    bus_rd(2'd1, d); check("R7 high inhibits", d, 8'h00);
    @(negedge clk); pulse_in = 1'b0;
    repeat (192) @(negedge clk);
    pulse_in = 1'b1;
    repeat (10) @(negedge clk);
    bus_rd(2'd1, d); check("R7 192 clocks low", d, 8'h03);
    bus_wr(2'd0, 8'h00);
    pin(1'b0);
  endtask

  task automatic t_ovf;
    logic [7:0] d;
    bus_wr(2'd0, 8'h40);
    bus_wr(2'd1, 8'hFE);
    bus_wr(2'd2, 8'h03);
    pin(1'b1); pin(1'b0);
    bus_rd(2'd1, d); check("R8 at FF", d, 8'hFF);
    check("R8 no ovf yet", {7'd0, ovf_flag}, 8'h00);
    pin(1'b1); pin(1'b0);
    bus_rd(2'd1, d); check("R8 wrapped", d, 8'h00);
    bus_rd(2'd2, d); check("R8 ovf set", d, 8'h03);
    bus_wr(2'd2, 8'h01);
    bus_rd(2'd2, d); check("R8 ovf cleared only", d, 8'h02);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    bus_wr(2'd0, 8'h40);
    bus_wr(2'd1, 8'h20);
    pin(1'b1);
    @(negedge clk); pulse_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = 2'd1; wr_data = 8'h80; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(2'd1, d); check("R10 write wins", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_disabled();
    t_evt_fall();
    t_evt_rise();
    t_gated_hi();
    t_gated_lo();
    t_ovf();
    t_prio();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule